// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the complete erase of one block of an on-chip flash array without help from software. A host presents a one-hot block selection together with an erase pulse length and strobes start. The sequencer then raises erase-enable for the programmed number of cycles. After a settle gap it switches the array into verify mode. For every longword of the block, it first writes a dummy byte 0xFF to the word-aligned address and then reads that word back. If any word is not all ones, it settles again, erases again and verifies again. It stops when a full pass reads clean or when the retry budget runs out.

While an operation is running, the sequencer holds an interrupt mask output high towards the interrupt controller. That mask covers the non-maskable source as well. A watchdog sums the erase-enable cycles of the operation and cuts the erase short if the total reaches its limit. At the default clock of 50 MHz, this limit is about 19.8 ms. To erase several blocks, the host starts one operation per block. Before the erase there is no programming step to zeros.

Top module: `flash_erase_seq`

## Requirements
- R1: A start is accepted only when exactly one bit of `blk_sel` is set. A zero or multi-bit select sets `fail` on the next cycle, issues no erase pulse and leaves `busy` low.
- R2: On an accepted start, `fl_erase` rises on the next clock edge with no write phase before it. Each erase pulse lasts `pulse_len` cycles, and `fl_blk` carries the selected one-hot block for the whole operation.
- R3: `fl_erase` and `fl_ev` are never high in the same cycle. Every switch between them has at least SETTLE cycles with both low.
- R4: Each verify read (`fl_rd`) is directly preceded by a one-cycle dummy write (`fl_wr`) of `fl_wdata` = 0xFF to the same address, and that address has bits [1:0] = 00. One pass reads all WORDS longwords of the block, whose byte base is index×WORDS×4.
- R5: When a pass reads every word as 0xFFFFFFFF, `done` pulses for exactly one cycle and `busy` falls. For a single-pass operation, `done` appears pulse_len+SETTLE+2×WORDS+1 cycles after the start is sampled.
- R6: After a pass with any word not all ones, the block settles and then issues another erase pulse. After MAX_TRY iterations without success, it sets `fail` and issues no further pulse.
- R7: When the erase-enable cycles summed over one operation reach WDT_LIMIT, `fl_erase` drops at once and both `fail` and `wdt_err` are set.
- R8: `irq_mask` is high in exactly the cycles where `busy` is high. `busy` covers the span from the accepted start until `done` or `fail`, and both are low after reset.
- R9: A start strobe that arrives while `busy` is high is ignored. The selected block, the outcome and the count of `done` pulses are unchanged.
- R10: `fail` and `wdt_err` hold until the next accepted start, which clears them. That start also clears the retry counter and the watchdog sum, so each operation gets the full budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start strobe |
| blk_sel | input | NBLK | One-hot block selection |
| pulse_len | input | LW | Erase pulse length in cycles, sampled at start |
| fl_erase | output | 1 | Erase enable to the array |
| fl_ev | output | 1 | Erase-verify mode to the array |
| fl_blk | output | NBLK | Selected block to the array |
| fl_wr | output | 1 | Dummy write strobe |
| fl_rd | output | 1 | Verify read strobe |
| fl_addr | output | AW | Byte address for the dummy write and the read |
| fl_wdata | output | 8 | Dummy write data |
| fl_rdata | input | 32 | Verify read data, valid in the `fl_rd` cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | Sticky failure flag |
| wdt_err | output | 1 | Sticky watchdog overflow flag |
| irq_mask | output | 1 | Mask for all interrupt sources, including non-maskable |

## Verification
The bench uses a flash stub in which each block turns to all ones only after a chosen number of accumulated erase cycles. This gives four cases:
- A block that clears within one pulse checks the exact timing of `done`.
- A block that needs three pulses separates the retry loop from an early exit.
- A block that never clears tells the retry limit apart from the watchdog.
- A single over-long pulse exercises only the watchdog.

Select values of zero, of two bits and of one bit separate rejection from acceptance. A stray start during a run, and two back-to-back operations that each use most of the watchdog budget, show that commands are ignored while busy and that the counters are cleared at each accepted start.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NBLK      = 4,
  parameter int WORDS     = 8,
  parameter int MAX_TRY   = 100,
  parameter int SETTLE    = 2,
  parameter int WDT_LIMIT = 990000,
  parameter int LW        = 16,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW = BW + WW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] blk_sel,
  input  logic [LW-1:0]   pulse_len,
  output logic            fl_erase,
  output logic            fl_ev,
  output logic [NBLK-1:0] fl_blk,
  output logic            fl_wr,
  output logic            fl_rd,
  output logic [AW-1:0]   fl_addr,
  output logic [7:0]      fl_wdata,
  input  logic [31:0]     fl_rdata,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            wdt_err,
  output logic            irq_mask
);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam int DW = $clog2(WDT_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_SET1, S_DWR, S_RD, S_SET2} st_t;
  st_t st;

  logic [NBLK-1:0] sel_q;
  logic [BW-1:0]   idx, idx_q;
  logic [WW-1:0]   widx;
  logic [LW-1:0]   len_q, cnt;
  logic [TW-1:0]   tries;
  logic [DW-1:0]   wdt;
  logic            bad;

  wire sel_ok  = (blk_sel != '0) && ((blk_sel & (blk_sel - 1'b1)) == '0);
  wire pulse_end = ({1'b0, cnt} + 1'b1) >= {1'b0, len_q};
  wire settled = (cnt == LW'(SETTLE - 1));
  wire bad_n   = bad | (fl_rdata != 32'hFFFF_FFFF);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NBLK; i++)
      if (blk_sel[i]) idx = BW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel_q <= '0; idx_q <= '0; widx <= '0; len_q <= '0;
      cnt <= '0; tries <= '0; wdt <= '0; bad <= 1'b0;
      done <= 1'b0; fail <= 1'b0; wdt_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (sel_ok) begin
            st <= S_ERASE; sel_q <= blk_sel; idx_q <= idx; len_q <= pulse_len;
            cnt <= '0; tries <= '0; wdt <= '0; fail <= 1'b0; wdt_err <= 1'b0;
          end else begin
            fail <= 1'b1; wdt_err <= 1'b0;
          end
        end
        S_ERASE: begin
          wdt <= wdt + 1'b1;
          if (wdt == DW'(WDT_LIMIT - 1)) begin
            st <= S_IDLE; fail <= 1'b1; wdt_err <= 1'b1;
          end else if (pulse_end) begin
            st <= S_SET1; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SET1: if (settled) begin
          st <= S_DWR; cnt <= '0; widx <= '0; bad <= 1'b0;
        end else cnt <= cnt + 1'b1;
        S_DWR: st <= S_RD;
        S_RD: begin
          bad <= bad_n;
          if (widx == WW'(WORDS - 1)) begin
            tries <= tries + 1'b1;
            if (!bad_n) begin
              st <= S_IDLE; done <= 1'b1;
            end else if (tries == TW'(MAX_TRY - 1)) begin
              st <= S_IDLE; fail <= 1'b1;
            end else begin
              st <= S_SET2; cnt <= '0;
            end
          end else begin
            widx <= widx + 1'b1; st <= S_DWR;
          end
        end
        S_SET2: if (settled) begin
          st <= S_ERASE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign irq_mask = busy;
  assign fl_erase = (st == S_ERASE);
  assign fl_ev    = (st == S_DWR) || (st == S_RD);
  assign fl_wr    = (st == S_DWR);
  assign fl_rd    = (st == S_RD);
  assign fl_addr  = {idx_q, widx, 2'b00};
  assign fl_wdata = 8'hFF;
  assign fl_blk   = busy ? sel_q : '0;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int NBLK = 4,
  parameter int AW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fl_erase,
  input logic            fl_ev,
  input logic [NBLK-1:0] fl_blk,
  input logic            fl_wr,
  input logic            fl_rd,
  input logic [AW-1:0]   fl_addr,
  input logic [7:0]      fl_wdata,
  input logic            busy,
  input logic            done,
  input logic            fail,
  input logic            wdt_err,
  input logic            irq_mask
);
  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fl_erase && fl_ev)); // R3
  AST_EV_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_ev) |-> !$past(fl_erase)); // R3
  AST_ERASE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_erase) |-> !$past(fl_ev)); // R3
  AST_DUMMY_WR: assert property (@(posedge clk) disable iff (!rst_n) fl_wr |-> (fl_addr[1:0] == 2'b00 && fl_wdata == 8'hFF && fl_ev)); // R4
  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) fl_rd |-> ($past(fl_wr) && $past(fl_addr) == fl_addr)); // R4
  AST_ERASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) fl_erase |-> $countones(fl_blk) == 1); // R1
  AST_BLK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(fl_blk)); // R9
  AST_DONE_XOR_FAIL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R5
  AST_MASK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (fl_erase || fl_ev) |-> irq_mask); // R8
  AST_WDT_CUTS: assert property (@(posedge clk) disable iff (!rst_n) wdt_err |-> (!fl_erase && fail)); // R7
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.NBLK(NBLK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_erase(fl_erase), .fl_ev(fl_ev), .fl_blk(fl_blk),
  .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .busy(busy),
  .done(done), .fail(fail), .wdt_err(wdt_err), .irq_mask(irq_mask)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int NBLK = 4, WORDS = 8, MAX_TRY = 100, SETTLE = 2, WDT = 5000, LW = 16;
  localparam int AW = 2 + 3 + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NBLK-1:0] blk_sel = '0;
  logic [LW-1:0] pulse_len = '0;
  logic fl_erase, fl_ev, fl_wr, fl_rd, busy, done, fail, wdt_err, irq_mask;
  logic [NBLK-1:0] fl_blk;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [31:0] fl_rdata;

  always #10 clk = ~clk;

  flash_erase_seq #(.NBLK(NBLK), .WORDS(WORDS), .MAX_TRY(MAX_TRY), .SETTLE(SETTLE),
                    .WDT_LIMIT(WDT), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .pulse_len(pulse_len),
    .fl_erase(fl_erase), .fl_ev(fl_ev), .fl_blk(fl_blk), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .fail(fail), .wdt_err(wdt_err), .irq_mask(irq_mask));

  // flash stub: a block reads all ones once it has seen need[b] erase cycles
  logic [31:0] mem [NBLK*WORDS];
  int need [NBLK];
  int acc  [NBLK];
  assign fl_rdata = mem[fl_addr[AW-1:2]];
  always @(posedge clk)
    if (fl_erase)
      for (int b = 0; b < NBLK; b++)
        if (fl_blk[b]) begin
          acc[b] = acc[b] + 1;
          if (acc[b] >= need[b])
            for (int w = 0; w < WORDS; w++) mem[b*WORDS + w] = 32'hFFFF_FFFF;
        end

  int checks = 0, failures = 0;
  int n_erase, n_pulse, n_done, n_wr, n_rd, v_excl, v_gap, v_wr, v_rd, v_irq, v_blk, v_range;
  int gap;
  logic p_erase, p_ev, p_wr, p_busy;
  logic [AW-1:0] p_addr;
  logic [NBLK-1:0] p_blk;
  int cur_blk;

  always @(negedge clk) begin
    if (fl_erase) n_erase++;
    if (fl_erase && !p_erase) begin
      n_pulse++;
      if (gap < SETTLE) v_gap++;
    end
    if (fl_ev && !p_ev && gap < SETTLE) v_gap++;
    if (fl_erase && fl_ev) v_excl++;
    if (fl_wr) begin
      n_wr++;
      if (fl_wdata != 8'hFF || fl_addr[1:0] != 2'b00) v_wr++;
    end
    if (fl_rd) begin
      n_rd++;
      if (!p_wr || p_addr != fl_addr) v_rd++;
      if (int'(fl_addr) < cur_blk*WORDS*4 || int'(fl_addr) >= (cur_blk+1)*WORDS*4) v_range++;
    end
    if (irq_mask != busy) v_irq++;
    if (busy && p_busy && fl_blk != p_blk) v_blk++;
    if (done) n_done++;
    gap = (fl_erase || fl_ev) ? 0 : gap + 1;
    p_erase = fl_erase; p_ev = fl_ev; p_wr = fl_wr; p_addr = fl_addr;
    p_busy = busy; p_blk = fl_blk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    n_erase = 0; n_pulse = 0; n_done = 0; n_wr = 0; n_rd = 0;
    v_excl = 0; v_gap = 0; v_wr = 0; v_rd = 0; v_irq = 0; v_blk = 0; v_range = 0;
  endtask

  task automatic setup_flash(input int n0, input int n1, input int n2, input int n3);
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    for (int b = 0; b < NBLK; b++) acc[b] = 0;
    for (int i = 0; i < NBLK*WORDS; i++) mem[i] = 32'h0;
  endtask

  // start at a negedge, then count negedges until done or fail
  task automatic run_op(input logic [NBLK-1:0] sel, input int len, output int cyc);
    blk_sel = sel; pulse_len = LW'(len); start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && !fail && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail && !wdt_err, "R8 reset status", {busy, done, fail, wdt_err}, 0);
    chk(!fl_erase && !fl_ev && !irq_mask, "R8 reset outputs", {fl_erase, fl_ev, irq_mask}, 0);
  endtask

  task automatic t_invalid();
    int cyc;
    setup_flash(1, 1, 1, 1); clear_stats();
    cur_blk = 0;
    run_op(4'b0000, 5, cyc);
    chk(fail == 1, "R1 zero select fail", fail, 1);
    chk(n_pulse == 0 && n_erase == 0, "R1 zero select no pulse", n_pulse, 0);
    run_op(4'b0110, 5, cyc);
    chk(fail == 1 && n_pulse == 0, "R1 two-bit select rejected", n_pulse, 0);
    chk(cyc == 1 && !busy, "R1 busy stays low", cyc, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_single();
    int cyc;
    setup_flash(1000, 10, 1000, 1000); clear_stats();
    cur_blk = 1;
    run_op(4'b0010, 12, cyc);
    chk(done == 1, "R5 done after one pass", done, 1);
    chk(fail == 0, "R10 fail cleared by accepted start", fail, 0);
    chk(cyc == 12 + SETTLE + 2*WORDS + 1, "R5 done latency", cyc, 12 + SETTLE + 2*WORDS + 1);
    chk(n_erase == 12 && n_pulse == 1, "R2 pulse length", n_erase, 12);
    chk(acc[1] == 12 && acc[0] == 0 && acc[2] == 0, "R2 erase on selected block", acc[1], 12);
    chk(mem[0] == 32'h0, "R2 other block untouched", int'(mem[0]), 0);
    chk(n_wr == WORDS && n_rd == WORDS, "R4 full pass reads", n_rd, WORDS);
    chk(v_wr == 0 && v_rd == 0 && v_range == 0, "R4 dummy write then read", v_wr + v_rd + v_range, 0);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R5 done is one cycle", done, 0);
    chk(n_done == 1, "R5 single done pulse", n_done, 1);
    chk(v_excl == 0 && v_gap == 0, "R3 mode exclusion and settle", v_excl + v_gap, 0);
    chk(v_irq == 0, "R8 irq mask tracks busy", v_irq, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_retry();
    int cyc;
    setup_flash(1000, 1000, 30, 1000); clear_stats();
    cur_blk = 2;
    run_op(4'b0100, 12, cyc);
    chk(done == 1 && fail == 0, "R6 success after retries", done, 1);
    chk(n_pulse == 3 && n_erase == 36, "R6 three erase pulses", n_pulse, 3);
    chk(n_rd == 3*WORDS, "R6 three verify passes", n_rd, 3*WORDS);
    chk(v_excl == 0 && v_gap == 0, "R3 settle between retries", v_excl + v_gap, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_limit();
    int cyc;
    setup_flash(1000000, 1000000, 1000000, 1000000); clear_stats();
    cur_blk = 3;
    run_op(4'b1000, 12, cyc);
    chk(fail == 1 && wdt_err == 0, "R6 retry limit fail", {fail, wdt_err}, 2);
    chk(n_pulse == MAX_TRY, "R6 pulse count at limit", n_pulse, MAX_TRY);
    chk(n_done == 0, "R6 no done", n_done, 0);
    repeat (10) @(negedge clk);
    chk(n_pulse == MAX_TRY && fail == 1, "R10 fail held, no more pulses", n_pulse, MAX_TRY);
  endtask

  task automatic t_wdt();
    int cyc;
    setup_flash(1000000, 1000000, 1000000, 1000000); clear_stats();
    cur_blk = 0;
    run_op(4'b0001, 6000, cyc);
    chk(fail == 1 && wdt_err == 1, "R7 watchdog flags", {fail, wdt_err}, 3);
    chk(n_erase == WDT, "R7 erase cut at limit", n_erase, WDT);
    chk(fl_erase == 0 && busy == 0, "R7 erase dropped", fl_erase, 0);
    repeat (5) @(negedge clk);
    chk(wdt_err == 1, "R10 wdt_err held", wdt_err, 1);
  endtask

  task automatic t_clear();
    int cyc;
    setup_flash(1000000, 4500, 4500, 1000000); clear_stats();
    cur_blk = 1;
    run_op(4'b0010, 1500, cyc);
    chk(done == 1 && wdt_err == 0, "R10 first long op done", done, 1);
    repeat (3) @(negedge clk);
    cur_blk = 2;
    run_op(4'b0100, 1500, cyc);
    chk(done == 1 && fail == 0 && wdt_err == 0, "R10 watchdog sum cleared", {fail, wdt_err}, 0);
    chk(n_erase == 9000, "R10 full budget each op", n_erase, 9000);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_busy_start();
    int cyc;
    setup_flash(20, 1000, 1000, 1000); clear_stats();
    cur_blk = 0;
    blk_sel = 4'b0001; pulse_len = 16'd12; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    blk_sel = 4'b1000; start = 1;
    @(negedge clk); start = 0; blk_sel = 4'b0001;
    cyc = 0;
    while (!done && !fail && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    chk(done == 1 && fail == 0, "R9 original op completes", done, 1);
    chk(acc[3] == 0 && v_blk == 0, "R9 stray select ignored", acc[3], 0);
    repeat (40) @(negedge clk);
    chk(n_done == 1 && !busy, "R9 no second operation", n_done, 1);
  endtask

  initial begin
    gap = 100; p_erase = 0; p_ev = 0; p_wr = 0; p_busy = 0; p_addr = '0; p_blk = '0; cur_blk = 0;
    setup_flash(1, 1, 1, 1); clear_stats();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_invalid();
    t_single();
    t_retry();
    t_limit();
    t_wdt();
    t_clear();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule